// File: doc/BRIEF.md
# Link Event Interrupt Controller

This block gathers six status events from a display-link transmitter and turns them into a single interrupt line for a host microcontroller. Three of the sources are asynchronous levels: hot-plug presence, receiver termination sense on the clock channel, and a video-stable indication. Any change on one of these, in either direction, counts as an event. The other three sources are single-cycle pulses that are synchronous to the block clock: a hung DDC bus, an audio FIFO overflow and a failed authentication.

Each event latches a sticky status bit. A per-event enable register decides which status bits take part in the interrupt, and a polarity bit selects the active level of the line. The line is active-low after reset. The host reaches four registers through a plain address / write-data / write-strobe / read-data port. The status register is cleared by writing ones to it. A read-only register shows the current synchronized levels, so the host can check the link state after it takes an interrupt.

Top module: `link_irq_ctrl`

## Requirements
- R1: Hot-plug level input: every change, rising or falling, sets status bit 0. The input passes through two synchronizer flops, so the bit is set on the third rising clock edge after the change.
- R2: Receiver-sense level input: every change, rising or falling, sets status bit 1. Timing is the same as R1.
- R3: Video-stable level input: every change, rising or falling, sets status bit 2. Timing is the same as R1.
- R4: A one-cycle pulse on the DDC-hang input sets status bit 3. A pulse on the audio-overflow input sets bit 4, and a pulse on the auth-fail input sets bit 5. The bit is set on the same clock edge that samples the pulse.
- R5: A status bit stays set until the host clears it, however long the source stays quiet.
- R6: A write to address 0 clears each status bit whose write-data bit is 1. Bits written as 0 are left unchanged. If a clear and a new event for the same bit happen in the same cycle, the bit stays set.
- R7: Address 1 holds the enable register, where bit i = 1 lets status bit i drive the interrupt. It resets to 0x00. A status bit still latches while its enable bit is 0.
- R8: The interrupt is asserted when (status AND enable) is nonzero. Its level is decided from the register values present after each clock edge, so a write to the enable or status register takes effect on irq_o at the same edge.
- R9: Bit 0 of address 2 is the polarity bit, and it resets to 0. With polarity 0 the asserted level of irq_o is 0 and the idle level is 1. With polarity 1 these are reversed.
- R10: Address 3 is read-only. Bits [2:0] show the synchronized hot-plug, receiver-sense and video-stable levels, available two edges after an input change. Writes to address 3 have no effect. All unused read-data bits at every address read 0.
- R11: After reset, status = 0x00, enable = 0x00, polarity = 0 and irq_o = 1. The synchronizers reset to low, so a level input that is high when reset is released causes a change event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hpd_lvl_i | input | 1 | Hot-plug presence level (asynchronous) |
| rxsense_lvl_i | input | 1 | Receiver termination sense level (asynchronous) |
| vstable_lvl_i | input | 1 | Incoming video stable level (asynchronous) |
| ddc_hang_p_i | input | 1 | DDC bus hang pulse (synchronous) |
| afifo_ovf_p_i | input | 1 | Audio FIFO overflow pulse (synchronous) |
| auth_fail_p_i | input | 1 | Authentication failure pulse (synchronous) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt line, registered |

## Verification
A pulse event shows in the status register and on irq_o after the single edge that samples it. A level event reaches the level register after two edges and the status register after three. Enable, polarity and clear writes act on irq_o at the edge that takes the write. The bench drives every input on the falling clock edge and counts whole clock cycles to the point where each result is due. For level events it checks one cycle early, to confirm the status is still clear, and then again at the due cycle. All reads are sampled a short delay after the falling edge, well away from the rising edge.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;

    // number of events and of level sources
    localparam int unsigned EVT_N = 6;
    localparam int unsigned LVL_N = 3;

    // status / enable bit positions (the host decodes these)
    localparam int unsigned EV_HPD  = 0;
    localparam int unsigned EV_RXS  = 1;
    localparam int unsigned EV_VID  = 2;
    localparam int unsigned EV_DDC  = 3;
    localparam int unsigned EV_AUD  = 4;
    localparam int unsigned EV_AUTH = 5;

    // register addresses
    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_ENABLE = 2'd1,
        RA_CTRL   = 2'd2,
        RA_LEVEL  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/lirq_level_watch.sv
// Synchronizes N asynchronous levels and flags a change in either direction.
module lirq_level_watch #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] change_o
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
        logic [N-1:0]             prev;
    } lw_state_t;

    lw_state_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = lvl_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
        s_d.prev = s_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o  = s_q.chain[LAST];
    assign change_o = level_o ^ s_q.prev;

    // R1 R2 R3: a new synchronized level is always flagged in that cycle
    assert_change_flagged_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(level_o)) |-> (change_o == (level_o ^ $past(level_o))));

endmodule

// File: rtl/lirq_event_core.sv
// Sticky status, enable, polarity and registered interrupt line.
module lirq_event_core #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic         en_we_i,
    input  logic [N-1:0] en_wdata_i,
    input  logic         pol_we_i,
    input  logic         pol_wdata_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] enable_o,
    output logic         pol_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] enable;
        logic         pol;
        logic         irq;
    } core_state_t;

    core_state_t c_d, c_q;
    logic        any_d;

    always_comb begin
        c_d = c_q;
        // an event outranks a clear of the same bit
        c_d.status = (c_q.status & ~clr_i) | evt_i;
        if (en_we_i)  c_d.enable = en_wdata_i;
        if (pol_we_i) c_d.pol    = pol_wdata_i;
        any_d = |(c_d.status & c_d.enable);
        c_d.irq = ~(any_d ^ c_d.pol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.status <= '0;
            c_q.enable <= '0;
            c_q.pol    <= 1'b0;
            c_q.irq    <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign status_o = c_q.status;
    assign enable_o = c_q.enable;
    assign pol_o    = c_q.pol;
    assign irq_o    = c_q.irq;

    // R4: every event lands in the status register on the next edge
    assert_event_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((c_q.status & $past(evt_i)) == $past(evt_i)));

    // R5: set bits not being cleared stay set
    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((c_q.status & $past(c_q.status & ~clr_i)) == $past(c_q.status & ~clr_i)));

    // R6: a clear without a competing event empties the bit
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((c_q.status & $past(clr_i & ~evt_i)) == '0));

    // R9: with nothing enabled and pending, the line sits at its idle level
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.status & c_q.enable) == '0) |-> (c_q.irq == ~c_q.pol));

    // R8: an enabled pending event drives the active level
    assert_active_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.status & c_q.enable) != '0) |-> (c_q.irq == c_q.pol));

endmodule

// File: rtl/link_irq_ctrl.sv
// Link event interrupt controller: top level with register decode.
module link_irq_ctrl
    import link_irq_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hpd_lvl_i,
    input  logic              rxsense_lvl_i,
    input  logic              vstable_lvl_i,
    input  logic              ddc_hang_p_i,
    input  logic              afifo_ovf_p_i,
    input  logic              auth_fail_p_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              reg_we_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(RA_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(RA_ENABLE);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(RA_CTRL);
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(RA_LEVEL);

    logic [LVL_N-1:0] lvl_raw, lvl_sync, lvl_chg;
    logic [EVT_N-1:0] evt_vec, clr_vec, status, enable;
    logic             pol;
    logic             wr_status, wr_enable, wr_ctrl;

    assign lvl_raw[EV_HPD] = hpd_lvl_i;
    assign lvl_raw[EV_RXS] = rxsense_lvl_i;
    assign lvl_raw[EV_VID] = vstable_lvl_i;

    lirq_level_watch #(
        .N      (LVL_N),
        .STAGES (SYNC_STAGES)
    ) i_level_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl_raw),
        .level_o  (lvl_sync),
        .change_o (lvl_chg)
    );

    always_comb begin
        evt_vec               = '0;
        evt_vec[LVL_N-1:0]    = lvl_chg;
        evt_vec[EV_DDC]       = ddc_hang_p_i;
        evt_vec[EV_AUD]       = afifo_ovf_p_i;
        evt_vec[EV_AUTH]      = auth_fail_p_i;
    end

    assign wr_status = reg_we_i && (reg_addr_i == A_STATUS);
    assign wr_enable = reg_we_i && (reg_addr_i == A_ENABLE);
    assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
    assign clr_vec   = wr_status ? reg_wdata_i[EVT_N-1:0] : '0;

    lirq_event_core #(
        .N (EVT_N)
    ) i_event_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_vec),
        .clr_i       (clr_vec),
        .en_we_i     (wr_enable),
        .en_wdata_i  (reg_wdata_i[EVT_N-1:0]),
        .pol_we_i    (wr_ctrl),
        .pol_wdata_i (reg_wdata_i[0]),
        .status_o    (status),
        .enable_o    (enable),
        .pol_o       (pol),
        .irq_o       (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_STATUS: reg_rdata_o[EVT_N-1:0] = status;
            A_ENABLE: reg_rdata_o[EVT_N-1:0] = enable;
            A_CTRL:   reg_rdata_o[0]         = pol;
            A_LEVEL:  reg_rdata_o[LVL_N-1:0] = lvl_sync;
            default:  reg_rdata_o            = '0;
        endcase
    end

    // R7 R8: an enabled pulse event reaches the pin one edge later
    assert_pulse_to_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_vec & enable)) && !wr_enable && !wr_ctrl) |=> (irq_o == pol));

    // R10: the level register holds while the synchronized levels hold
    assert_level_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_addr_i == A_LEVEL && lvl_chg == '0)
            |=> (lvl_sync == $past(lvl_sync)));

endmodule

// File: tb/test_link_irq_ctrl.sv
module test_link_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hpd = 1'b0, rxs = 1'b0, vst = 1'b0;
    logic       ddc = 1'b0, aud = 1'b0, auth = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    link_irq_ctrl i_link_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .hpd_lvl_i     (hpd),
        .rxsense_lvl_i (rxs),
        .vstable_lvl_i (vst),
        .ddc_hang_p_i  (ddc),
        .afifo_ovf_p_i (aud),
        .auth_fail_p_i (auth),
        .reg_addr_i    (addr),
        .reg_wdata_i   (wdata),
        .reg_we_i      (we),
        .reg_rdata_o   (rdata),
        .irq_o         (irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick(1);
        we = 1'b0; wdata = '0;
        #1;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, $sformatf("reg%0d", a), v, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        #1 check(req, "irq_o", {7'd0, irq}, {7'd0, exp});
    endtask

    task automatic t_reset;
        chk_reg("R11", 2'd0, 8'h00);
        chk_reg("R11", 2'd1, 8'h00);
        chk_reg("R11", 2'd2, 8'h00);
        chk_reg("R10", 2'd3, 8'h00);
        chk_irq("R11", 1'b1);
    endtask

    task automatic t_hpd;
        wr(2'd1, 8'h3F);
        hpd = 1'b1;
        tick(2);
        chk_reg("R10", 2'd3, 8'h01);
        chk_reg("R1", 2'd0, 8'h00);
        tick(1);
        chk_reg("R1", 2'd0, 8'h01);
        chk_irq("R8", 1'b0);
        wr(2'd0, 8'h01);
        chk_reg("R6", 2'd0, 8'h00);
        chk_irq("R8", 1'b1);
        hpd = 1'b0;
        tick(3);
        chk_reg("R1", 2'd0, 8'h01);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_rx_vid;
        rxs = 1'b1;
        tick(3);
        chk_reg("R2", 2'd0, 8'h02);
        wr(2'd0, 8'h02);
        vst = 1'b1;
        tick(3);
        chk_reg("R3", 2'd0, 8'h04);
        wr(2'd0, 8'h04);
        vst = 1'b0;
        tick(3);
        chk_reg("R3", 2'd0, 8'h04);
        vst = 1'b1;
        tick(3);
        wr(2'd0, 8'hFF);
        chk_reg("R6", 2'd0, 8'h00);
    endtask

    task automatic t_pulses;
        ddc = 1'b1; tick(1); ddc = 1'b0;
        chk_reg("R4", 2'd0, 8'h08);
        aud = 1'b1; tick(1); aud = 1'b0;
        chk_reg("R4", 2'd0, 8'h18);
        auth = 1'b1; tick(1); auth = 1'b0;
        chk_reg("R4", 2'd0, 8'h38);
        tick(6);
        chk_reg("R5", 2'd0, 8'h38);
        wr(2'd0, 8'h08);
        chk_reg("R6", 2'd0, 8'h30);
        wr(2'd0, 8'h00);
        chk_reg("R6", 2'd0, 8'h30);
        wr(2'd0, 8'h30);
    endtask

    task automatic t_race;
        auth = 1'b1;
        wr(2'd0, 8'h20);
        auth = 1'b0;
        chk_reg("R6", 2'd0, 8'h20);
        wr(2'd0, 8'h20);
        chk_reg("R6", 2'd0, 8'h00);
    endtask

    task automatic t_mask;
        wr(2'd1, 8'h00);
        ddc = 1'b1; tick(1); ddc = 1'b0;
        chk_reg("R7", 2'd0, 8'h08);
        chk_irq("R7", 1'b1);
        wr(2'd1, 8'h08);
        chk_irq("R8", 1'b0);
        wr(2'd1, 8'h10);
        chk_irq("R7", 1'b1);
        chk_reg("R7", 2'd1, 8'h10);
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h3F);
    endtask

    task automatic t_pol;
        wr(2'd2, 8'h01);
        chk_reg("R9", 2'd2, 8'h01);
        chk_irq("R9", 1'b0);
        aud = 1'b1; tick(1); aud = 1'b0;
        chk_irq("R9", 1'b1);
        wr(2'd0, 8'h10);
        chk_irq("R9", 1'b0);
        wr(2'd2, 8'h00);
        chk_irq("R9", 1'b1);
    endtask

    task automatic t_levels;
        // hpd low, receiver sense high, video stable high
        chk_reg("R10", 2'd3, 8'h06);
        wr(2'd3, 8'hFF);
        chk_reg("R10", 2'd3, 8'h06);
        chk_reg("R10", 2'd0, 8'h00);
        chk_reg("R10", 2'd1, 8'h3F);
        chk_reg("R10", 2'd2, 8'h00);
    endtask

    task automatic t_reset_high;
        hpd = 1'b1;
        tick(1);
        rst_n = 1'b0;
        tick(2);
        chk_irq("R11", 1'b1);
        chk_reg("R11", 2'd0, 8'h00);
        rst_n = 1'b1;
        tick(3);
        chk_reg("R11", 2'd0, 8'h07);
        chk_irq("R11", 1'b1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_hpd();
        t_rx_vid();
        t_pulses();
        t_race();
        t_mask();
        t_pol();
        t_levels();
        t_reset_high();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule